// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM that answers on a three-wire synchronous serial bus: a select line, a serial clock and a data line in, plus one data line out. The memory holds 64 words of 16 bits in flip-flops. All pins are sampled on the chip's system clock. A rising edge of the serial clock, found by comparing against the previous sample, is the only event that moves the protocol forward. The select line is watched as a level.

A command starts with a start bit. This is the first serial-clock rise seen while select and data-in are both high. Two opcode bits and six address bits follow, most significant bit first. The device then does one of these:
- streams a stored word out;
- takes in 16 more bits and writes one word or every word;
- erases one word or every word to all ones;
- sets or clears a write-enable latch.

After a programming command the data-out line shows status. It reads low (busy) until select has dropped and come back high. It then reads high (ready) until select drops again. Programming delays are not modelled, so the work is always complete by the time the ready status is shown.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, every word reads 16'hFFFF, and `sdo_en` is low.
- R2: While in idle, serial-clock rises with `di` low are ignored. The first rise with `cs` and `di` both high is taken as the start bit.
- R3: The 8 bits after the start bit are the opcode (2 bits) followed by the address (6 bits), most significant bit first. Opcode 2'b10 is a read. After the 8th of these rises, `sdo` shows bit 15 of the addressed word. Each later rise moves `sdo` to the next lower bit. The 16th later rise releases `sdo_en`.
- R4: Opcode 2'b01 takes 16 more data bits, most significant bit first, and stores them at the address when write-enable is set.
- R5: Opcode 2'b11 sets the addressed word to 16'hFFFF when write-enable is set.
- R6: For opcode 2'b00 the address bits [5:4] pick a sub-command, and address bits [3:0] are ignored. Sub-command 2'b11 sets write-enable. Sub-command 2'b00 clears it.
- R7: Opcode 2'b00 with sub-command 2'b01 takes 16 data bits and writes them to every word. Sub-command 2'b10 sets every word to 16'hFFFF. Both happen only when write-enable is set.
- R8: While write-enable is clear, single write, single erase, write-all and erase-all leave memory unchanged, but still give the busy/ready status.
- R9: After the last bit of any programming command, `sdo` is driven low. It stays driven low after `cs` falls and for as long as `cs` stays low. When `cs` rises, `sdo` is driven high. The next fall of `cs` returns the device to idle.
- R10: `cs` low in any state other than the busy/ready sequence returns the device to idle. Any partial command is discarded and `sdo_en` drops.
- R11: When no read data and no status is being shown, including after a write-enable set or clear, `sdo_en` is low and `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; its rising edge advances the protocol |
| di | input | 1 | Serial data into the device |
| sdo | output | 1 | Serial data out (read bits or busy/ready status) |
| sdo_en | output | 1 | High while `sdo` is actively driven |

## Verification
The assertions assume that `cs`, `sk` and `di` are already synchronous to `clk`. They also assume that each serial-clock level is held for at least one system clock, so that every rise is seen exactly once. The stimulus meets this by changing pins only on the falling edge of `clk` and holding each serial-clock phase for two system clocks. It holds `di` steady across each rise and changes `cs` only while the serial clock is not rising. The properties on the busy/ready path further assume that select toggles with no serial-clock activity in between, and every programming sequence in the bench is run that way.

// File: rtl/uwire_eeprom_pkg.sv
package uwire_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_SEND,
    ST_DONE,
    ST_BUSY_HI,
    ST_BUSY_LO,
    ST_READY
  } ue_state_t;

  typedef enum logic [2:0] {
    K_READ,
    K_WRITE,
    K_ERASE,
    K_WEN_ON,
    K_WEN_OFF,
    K_WRALL,
    K_ERALL
  } ue_kind_t;

  // Map opcode and the two sub-command bits onto a command kind.
  function automatic ue_kind_t ue_decode(input logic [1:0] op, input logic [1:0] sub);
    ue_kind_t k;
    case (op)
      2'b10:   k = K_READ;
      2'b01:   k = K_WRITE;
      2'b11:   k = K_ERASE;
      default: begin
        case (sub)
          2'b11:   k = K_WEN_ON;
          2'b00:   k = K_WEN_OFF;
          2'b01:   k = K_WRALL;
          default: k = K_ERALL;
        endcase
      end
    endcase
    return k;
  endfunction

  // Commands that end in the busy/ready status sequence.
  function automatic logic ue_is_prog(input ue_kind_t k);
    return (k == K_WRITE) || (k == K_ERASE) || (k == K_WRALL) || (k == K_ERALL);
  endfunction

  // Commands that need a data phase after the header.
  function automatic logic ue_needs_data(input ue_kind_t k);
    return (k == K_WRITE) || (k == K_WRALL);
  endfunction

endpackage

// File: rtl/uwire_sk_edge.sv
module uwire_sk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  output logic sk_rise
);
  logic sk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  assign sk_rise = sk & ~sk_q;

  // R3: each rise is reported for a single system clock only
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sk_rise |=> !sk_rise);
endmodule

// File: rtl/uwire_eeprom_store.sv
module uwire_eeprom_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic hit;
    assign hit = we && (all || (waddr == ADDR_W'(i)));
    always_ff @(posedge clk) begin
      if (!rst_n)   mem[i] <= '1;
      else if (hit) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R7: a broadcast write leaves the first and last word equal
  a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (we && all) |=> (mem[0] == mem[WORDS-1]));
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwire_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int OP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              sk_rise,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              mem_we,
  output logic              mem_all,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic              wen
);
  localparam int HDR_W = OP_W + ADDR_W;
  localparam int MAXB  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int CNT_W = $clog2(MAXB) + 1;

  ue_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W-1:0] out_q;
  logic [ADDR_W-1:0] addr_q;
  logic              all_q;
  logic              wen_q;

  logic [HDR_W-1:0]  hdr_nx;
  logic [DATA_W-1:0] dat_nx;
  logic [OP_W-1:0]   op_nx;
  logic [ADDR_W-1:0] adr_nx;
  ue_kind_t          kind;
  logic              ev;
  logic              hdr_last;
  logic              dat_last;

  assign ev       = sk_rise & cs;
  assign hdr_nx   = {hdr_q[HDR_W-2:0], di};
  assign dat_nx   = {dat_q[DATA_W-2:0], di};
  assign op_nx    = hdr_nx[HDR_W-1 -: OP_W];
  assign adr_nx   = hdr_nx[ADDR_W-1:0];
  assign kind     = ue_decode(op_nx[1:0], adr_nx[ADDR_W-1 -: 2]);
  assign hdr_last = ev && (state_q == ST_HDR) && (cnt_q == CNT_W'(HDR_W - 1));
  assign dat_last = ev && (state_q == ST_DATA) && (cnt_q == CNT_W'(DATA_W - 1));

  assign rd_addr  = adr_nx;
  assign mem_we   = wen_q && (dat_last ||
                    (hdr_last && ((kind == K_ERASE) || (kind == K_ERALL))));
  assign mem_all  = hdr_last ? (kind == K_ERALL) : all_q;
  assign mem_addr = hdr_last ? adr_nx : addr_q;
  assign mem_data = hdr_last ? '1 : dat_nx;
  assign wen      = wen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
      out_q   <= '0;
      addr_q  <= '0;
      all_q   <= 1'b0;
      wen_q   <= 1'b0;
    end else if (!cs) begin
      cnt_q <= '0;
      case (state_q)
        ST_BUSY_HI: state_q <= ST_BUSY_LO;
        ST_BUSY_LO: state_q <= ST_BUSY_LO;
        default:    state_q <= ST_IDLE;
      endcase
    end else if (state_q == ST_BUSY_LO) begin
      state_q <= ST_READY;
    end else if (sk_rise) begin
      case (state_q)
        ST_IDLE: begin
          if (di) begin
            state_q <= ST_HDR;
            cnt_q   <= '0;
            hdr_q   <= '0;
          end
        end
        ST_HDR: begin
          hdr_q <= hdr_nx;
          cnt_q <= cnt_q + 1'b1;
          if (hdr_last) begin
            cnt_q  <= '0;
            addr_q <= adr_nx;
            all_q  <= (kind == K_WRALL);
            case (kind)
              K_READ: begin
                out_q   <= rd_data;
                state_q <= ST_SEND;
              end
              K_WEN_ON: begin
                wen_q   <= 1'b1;
                state_q <= ST_DONE;
              end
              K_WEN_OFF: begin
                wen_q   <= 1'b0;
                state_q <= ST_DONE;
              end
              default: state_q <= ue_needs_data(kind) ? ST_DATA : ST_BUSY_HI;
            endcase
          end
        end
        ST_DATA: begin
          dat_q <= dat_nx;
          cnt_q <= cnt_q + 1'b1;
          if (dat_last) state_q <= ST_BUSY_HI;
        end
        ST_SEND: begin
          out_q <= {out_q[DATA_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sdo    = 1'b0;
    sdo_en = 1'b0;
    case (state_q)
      ST_SEND:              begin sdo = out_q[DATA_W-1]; sdo_en = 1'b1; end
      ST_BUSY_HI, ST_BUSY_LO: begin sdo = 1'b0;          sdo_en = 1'b1; end
      ST_READY:             begin sdo = 1'b1;            sdo_en = 1'b1; end
      default:              ;
    endcase
  end

  // R2: a rise with data low in idle is not a start bit
  a_r2_no_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sk_rise && cs && !di) |=> (state_q == ST_IDLE));

  // R6: the latch only moves on a serial-clock rise
  a_r6_wen_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen_q) |-> $past(sk_rise));

  // R9: select falling during busy keeps a driven low status
  a_r9_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY_HI && !cs) |=> (state_q == ST_BUSY_LO && sdo_en && !sdo));

  // R9: select rising again shows ready
  a_r9_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY_LO && cs) |=> (sdo_en && sdo));

  // R10: select low outside the status sequence aborts to idle
  a_r10_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && state_q != ST_BUSY_HI && state_q != ST_BUSY_LO) |=> (state_q == ST_IDLE && !sdo_en));

  // R3: header counter never runs past the header length
  a_r3_hdr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR) |-> (cnt_q < CNT_W'(HDR_W)));
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int OP_W   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic sdo,
  output logic sdo_en
);
  logic              sk_rise;
  logic              mem_we;
  logic              mem_all;
  logic              wen;
  logic [ADDR_W-1:0] mem_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] mem_data;
  logic [DATA_W-1:0] rd_data;

  uwire_sk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sk      (sk),
    .sk_rise (sk_rise)
  );

  uwire_eeprom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .di       (di),
    .sk_rise  (sk_rise),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .mem_we   (mem_we),
    .mem_all  (mem_all),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .sdo      (sdo),
    .sdo_en   (sdo_en),
    .wen      (wen)
  );

  uwire_eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .all   (mem_all),
    .waddr (mem_addr),
    .wdata (mem_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R8: no array write unless the write-enable latch is set
  a_r8_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen);
endmodule

// File: tb/tb_uwire_eeprom.sv
module tb_uwire_eeprom;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic sdo;
  logic sdo_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_mem [64];

  always #4 clk = ~clk;

  uwire_eeprom dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic d);
    @(negedge clk); di = d; sk = 1'b0;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk); cs = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input logic [5:0] a);
    logic [7:0] h;
    h = {op, a};
    pulse(1'b1);
    for (int i = 7; i >= 0; i--) pulse(h[i]);
  endtask

  task automatic read_word(input logic [5:0] a, output logic [15:0] v, output logic rel);
    set_cs(1'b1);
    header(2'b10, a);
    v[15] = sdo;
    for (int i = 14; i >= 0; i--) begin
      pulse(1'b0);
      v[i] = sdo;
    end
    pulse(1'b0);
    rel = !sdo_en && !sdo;
    set_cs(1'b0);
  endtask

  // Busy, busy under low select, ready, then released (R9).
  task automatic status_seq(input string tag);
    check(sdo_en && !sdo, {tag, " R9 busy after last bit"}, {sdo_en, sdo}, 2'b10);
    set_cs(1'b0);
    check(sdo_en && !sdo, {tag, " R9 busy with cs low"}, {sdo_en, sdo}, 2'b10);
    set_cs(1'b1);
    check(sdo_en && sdo, {tag, " R9 ready on cs high"}, {sdo_en, sdo}, 2'b11);
    set_cs(1'b0);
    check(!sdo_en, {tag, " R9 released after cs low"}, sdo_en, 1'b0);
  endtask

  task automatic prog_data(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                           input string tag);
    set_cs(1'b1);
    header(op, a);
    for (int i = 15; i >= 0; i--) pulse(d[i]);
    status_seq(tag);
  endtask

  task automatic prog_nodata(input logic [1:0] op, input logic [5:0] a, input string tag);
    set_cs(1'b1);
    header(op, a);
    status_seq(tag);
  endtask

  task automatic latch_cmd(input logic [1:0] sub, input logic [3:0] junk);
    set_cs(1'b1);
    header(2'b00, {sub, junk});
    check(!sdo_en && !sdo, "R11 no drive after latch command", {sdo_en, sdo}, 2'b00);
    set_cs(1'b0);
  endtask

  task automatic sweep(input string tag);
    logic [15:0] v;
    logic rel;
    int bad;
    bad = 0;
    for (int a = 0; a < 64; a++) begin
      read_word(6'(a), v, rel);
      if (v !== exp_mem[a] || !rel) begin
        bad++;
        if (bad == 1) check(1'b0, tag, {15'd0, rel, v}, {16'd1, exp_mem[a]});
      end
    end
    if (bad == 0) check(1'b1, tag, 0, 0);
  endtask

  function automatic logic [15:0] pat(input int a);
    return (16'(a) * 16'h0405) ^ 16'hA5C3;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic rel;
    for (int a = 0; a < 64; a++) exp_mem[a] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sdo_en && !sdo, "R1 R11 outputs idle after reset", {sdo_en, sdo}, 2'b00);

    // R1: contents all ones after reset
    sweep("R1 reset contents all ones");

    // R2: leading zero clocks before the start bit are ignored
    set_cs(1'b1);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    check(!sdo_en, "R2 no response to zero clocks", sdo_en, 1'b0);
    header(2'b10, 6'd7);
    v[15] = sdo;
    for (int i = 14; i >= 0; i--) begin pulse(1'b0); v[i] = sdo; end
    check(v == 16'hFFFF, "R2 R3 read after leading zeros", v, 16'hFFFF);
    set_cs(1'b0);

    // R8: write while the latch is clear
    prog_data(2'b01, 6'd5, 16'h1234, "R8 write blocked");
    read_word(6'd5, v, rel);
    check(v == 16'hFFFF, "R8 word unchanged after blocked write", v, 16'hFFFF);

    // R6: set write-enable with arbitrary low address bits
    latch_cmd(2'b11, 4'b1010);

    // R4, R3: write every word, then read all back
    for (int a = 0; a < 64; a++) begin
      prog_data(2'b01, 6'(a), pat(a), "R4 write");
      exp_mem[a] = pat(a);
    end
    sweep("R4 R3 per-word write readback");

    // R5: erase one word, neighbours untouched
    prog_nodata(2'b11, 6'd9, "R5 erase");
    exp_mem[9] = 16'hFFFF;
    read_word(6'd9, v, rel);
    check(v == 16'hFFFF, "R5 erased word", v, 16'hFFFF);
    read_word(6'd10, v, rel);
    check(v == exp_mem[10], "R5 neighbour kept", v, exp_mem[10]);

    // R10: abort during a data phase
    set_cs(1'b1);
    header(2'b01, 6'd3);
    for (int i = 0; i < 8; i++) pulse(1'b0);
    set_cs(1'b0);
    check(!sdo_en, "R10 released on abort", sdo_en, 1'b0);
    read_word(6'd3, v, rel);
    check(v == exp_mem[3], "R10 aborted write discarded", v, exp_mem[3]);

    // R10: abort during a read
    set_cs(1'b1);
    header(2'b10, 6'd4);
    pulse(1'b0); pulse(1'b0);
    check(sdo_en, "R10 read driving before abort", sdo_en, 1'b1);
    set_cs(1'b0);
    check(!sdo_en && !sdo, "R10 read abort releases", {sdo_en, sdo}, 2'b00);

    // R7: write-all then erase-all
    prog_data(2'b00, 6'b01_0110, 16'h3C5A, "R7 write-all");
    for (int a = 0; a < 64; a++) exp_mem[a] = 16'h3C5A;
    sweep("R7 write-all contents");
    prog_nodata(2'b00, 6'b10_0001, "R7 erase-all");
    for (int a = 0; a < 64; a++) exp_mem[a] = 16'hFFFF;
    sweep("R7 erase-all contents");

    // R6, R8: clear the latch, then all programming is blocked
    prog_data(2'b00, 6'b01_0000, 16'h00FF, "R7 write-all second");
    for (int a = 0; a < 64; a++) exp_mem[a] = 16'h00FF;
    latch_cmd(2'b00, 4'b0111);
    prog_nodata(2'b11, 6'd2, "R8 erase blocked");
    prog_nodata(2'b00, 6'b10_1111, "R8 erase-all blocked");
    prog_data(2'b00, 6'b01_0000, 16'hBEEF, "R8 write-all blocked");
    prog_data(2'b01, 6'd40, 16'h0001, "R8 write blocked");
    sweep("R6 R8 contents kept with latch clear");

    summary();
    $finish;
  end
endmodule